// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM whose read and write data phases both fall two clock cycles after the command. Because the two phases line up, a read may follow a write, or a write may follow a read, on consecutive cycles with no idle bus cycle between them. The clock, address, direction, chip enables and byte write enables are all registered on the rising edge. A two-stage command pipeline carries each access to its data phase.

A clock-enable input stalls the whole pipeline, and so does a sleep input. Three chip enables of mixed polarity select the device. A small on-chip generator produces four-beat bursts in either linear or interleaved order. The bidirectional data bus is split into three signals: a data input, a registered data output, and a drive-enable output that the output enable gates asynchronously. The memory depth and the byte count and width are parameters.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded at enabled edge k presents the word on data_o after the second enabled edge that follows (k+2). From then on drive_o is high while oe_ni is low.
- R2: A write loaded at edge k takes data_i as it is sampled at enabled edge k+2. Byte b covers data bits [9b+8:9b] and is written only when bw_ni[b] was low on the cycle that issued the write.
- R3: Reads and writes can alternate on every cycle with no idle cycles. A read issued one or two cycles after a write to the same address returns the newly written bytes.
- R4: While cen_ni is high every other synchronous input is ignored, and all pipeline state and outputs hold. Latency counts enabled edges only.
- R5: A load takes place only when adv_i=0, ce1_ni=0, ce2_i=1 and ce3_ni=0. Any other chip-enable value with adv_i=0 is a deselect, which starts no access and ends any burst. Accesses already in the pipeline still complete.
- R6: drive_o falls two enabled edges after a deselect or after a write load.
- R7: oe_ni high forces drive_o low at once, without a clock edge, and leaves data_o and the pipeline unaffected.
- R8: adv_i=1 during a burst issues the next beat. The low two address bits become (start+n) mod 4 when burst_lin_i=1 and start XOR n when burst_lin_i=0, and they wrap after the fourth beat. Each beat keeps the direction of its load cycle, and wr_ni and addr_i are ignored on advance cycles.
- R9: bw_ni is sampled on every beat of a burst write and is ignored on reads.
- R10: adv_i=1 with no burst in progress, whether after reset or after a deselect, issues no access.
- R11: sleep_i high stalls the block in the same way as cen_ni high, and the memory contents are kept.
- R12: Reset empties the pipeline and holds drive_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| sleep_i | input | 1 | Sleep, stalls the internal clock |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| wr_ni | input | 1 | 0 = write, 1 = read (load cycles only) |
| bw_ni | input | NUM_BYTES | Byte write enables, active low |
| addr_i | input | ADDR_W | Word address |
| burst_lin_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| data_i | input | NUM_BYTES*BYTE_W | Write data for the data phase |
| data_o | output | NUM_BYTES*BYTE_W | Registered read data |
| drive_o | output | 1 | Bus drive enable |

## Verification
A corrupted pipeline stage shows up as a wrong word on data_o, or as drive_o in the wrong state, exactly two enabled edges after the command that went wrong. The bench therefore compares both outputs on every cycle against a reference memory and a two-stage expectation pipeline. A burst counter that skips or repeats a beat appears as a mismatch on the first read of a burst that was written in order. A stall that leaks through changes data_o or drive_o on the very next cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {BURST_XOR = 1'b0, BURST_INC = 1'b1} burst_order_e;

  // low two address bits of beat n of a four-beat burst
  function automatic logic [1:0] burst_ofs(logic [1:0] start, logic [1:0] step, burst_order_e ord);
    return (ord == BURST_INC) ? start + step : start ^ step;
  endfunction
endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic              adv_i,
  input  logic              lin_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              act_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nxt;
  burst_order_e      ord;

  assign cnt_nxt = cnt_q + 2'd1;
  assign ord     = burst_order_e'(lin_i);
  assign addr_o  = {base_q[ADDR_W-1:2], burst_ofs(base_q[1:0], cnt_nxt, ord)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_o  <= 1'b0;
      wr_o   <= 1'b0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        act_o  <= 1'b1;
        wr_o   <= wr_i;
      end else if (stop_i) begin
        act_o  <= 1'b0;
      end else if (adv_i && act_o) begin
        cnt_q  <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9,
  localparam int DATA_W   = NUM_BYTES * BYTE_W,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [NUM_BYTES-1:0] be_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (be_i[b]) mem_q[addr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cen_ni,
  input  logic                 sleep_i,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 adv_i,
  input  logic                 wr_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 burst_lin_i,
  input  logic                 oe_ni,
  input  logic [DATA_W-1:0]    data_i,
  output logic [DATA_W-1:0]    data_o,
  output logic                 drive_o
);
  typedef struct packed {
    logic                 v;
    logic                 wr;
    logic [ADDR_W-1:0]    addr;
    logic [NUM_BYTES-1:0] be;
  } cmd_t;

  logic en, sel, load, desel;
  logic b_act, b_wr;
  logic [ADDR_W-1:0] b_addr;
  cmd_t issue, s1_q, s2_q;
  logic [DATA_W-1:0] rd_data, data_q;
  logic out_v_q;

  assign en    = !cen_ni && !sleep_i;
  assign sel   = !ce1_ni && ce2_i && !ce3_ni;
  assign load  = !adv_i && sel;
  assign desel = !adv_i && !sel;

  zbt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (load),
    .stop_i (desel),
    .adv_i  (adv_i),
    .lin_i  (burst_lin_i),
    .wr_i   (!wr_ni),
    .addr_i (addr_i),
    .act_o  (b_act),
    .wr_o   (b_wr),
    .addr_o (b_addr)
  );

  always_comb begin
    issue.v    = load || (adv_i && b_act);
    issue.wr   = load ? !wr_ni : b_wr;
    issue.addr = load ? addr_i : b_addr;
    issue.be   = issue.wr ? ~bw_ni : '0;  // masks only matter on writes
  end

  zbt_mem_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (en && s2_q.v && s2_q.wr),
    .be_i    (s2_q.be),
    .addr_i  (s2_q.addr),
    .wdata_i (data_i),
    .rdata_o (rd_data)
  );

  // writes commit at their data edge, so any later read sees them directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= '0;
      s2_q    <= '0;
      out_v_q <= 1'b0;
      data_q  <= '0;
    end else if (en) begin
      s1_q <= issue;
      s2_q <= s1_q;
      if (s2_q.v && !s2_q.wr) begin
        out_v_q <= 1'b1;
        data_q  <= rd_data;
      end else begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign drive_o = out_v_q && !oe_ni;
endmodule

// File: rtl/zbt_sram_checker.sv
module zbt_sram_checker #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cen_ni,
  input logic                 sleep_i,
  input logic                 ce1_ni,
  input logic                 ce2_i,
  input logic                 ce3_ni,
  input logic                 adv_i,
  input logic                 wr_ni,
  input logic [NUM_BYTES-1:0] bw_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 burst_lin_i,
  input logic                 oe_ni,
  input logic [DATA_W-1:0]    data_i,
  input logic [DATA_W-1:0]    data_o,
  input logic                 drive_o
);
  logic en_c, sel_c;
  assign en_c  = !cen_ni && !sleep_i;
  assign sel_c = !ce1_ni && ce2_i && !ce3_ni;

  a_r4_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable(data_o));

  a_r11_sleep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(data_o));

  a_r6_desel_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && !adv_i && !sel_c) ##1 en_c ##1 en_c |=> !drive_o);

  a_r6_write_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && !adv_i && sel_c && !wr_ni) ##1 en_c ##1 en_c |=> !drive_o);

  a_r1_read_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && !adv_i && sel_c && wr_ni) ##1 en_c ##1 en_c ##1 !oe_ni |-> drive_o);

  a_r7_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);

  always_comb begin
    if (!rst_ni) a_r12_reset_idle: assert (!drive_o);
  end
endmodule

bind zbt_sram zbt_sram_checker #(
  .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)
) u_chk (.*);

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;
  localparam int AW = 6, NB = 4, BWD = 9, DW = NB * BWD, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, cen_n = 0, slp = 0;
  logic ce1_n = 1, ce2 = 0, ce3_n = 1, adv = 0, wr_n = 1, lin = 1, oe_n = 0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic drv;

  zbt_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BWD)) u_zbt_sram (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_n), .sleep_i(slp),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .adv_i(adv), .wr_ni(wr_n),
    .bw_ni(bw_n), .addr_i(addr), .burst_lin_i(lin), .oe_ni(oe_n),
    .data_i(din), .data_o(dout), .drive_o(drv)
  );

  always #10 clk = ~clk;

  typedef struct {bit v; bit wr; int a; logic [NB-1:0] m;} op_t;
  op_t p1, p2;
  logic [DW-1:0] ref_mem [DEPTH];
  bit ev = 0;
  logic [DW-1:0] ed = '0;
  int b_base = 0, b_n = 0, seed = 1;
  bit b_act = 0, b_wr = 0, done = 0;
  string req = "R12";
  int checks = 0, errs = 0;

  function automatic logic [DW-1:0] pat(int a, int s);
    logic [63:0] x;
    x = (64'(a) + 64'd1) * 64'h9E37_79B9_7F4A_7C15 ^ (64'(s) * 64'hC2B2_AE3D_27D4_EB4F);
    return x[DW-1:0];
  endfunction

  function automatic int baddr(int base, int n, bit l);
    return l ? ((base & ~3) | ((base + n) & 3)) : (base ^ n);
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: present write data for stage 2, clock, update model, check at negedge
  task automatic tick();
    bit en, sel;
    op_t nw;
    din = (p2.v && p2.wr) ? pat(p2.a, seed) : '0;
    @(posedge clk);
    en = !cen_n && !slp;
    if (en) begin
      if (p2.v && p2.wr)
        for (int b = 0; b < NB; b++)
          if (p2.m[b]) ref_mem[p2.a][b*BWD +: BWD] = din[b*BWD +: BWD];
      ev = p2.v && !p2.wr;
      if (ev) ed = ref_mem[p2.a];
      nw.v = 0; nw.wr = 0; nw.a = 0; nw.m = '0;
      sel = !ce1_n && ce2 && !ce3_n;
      if (!adv && sel) begin
        b_base = int'(addr); b_n = 0; b_act = 1; b_wr = !wr_n;
        nw.v = 1; nw.wr = !wr_n; nw.a = int'(addr);
      end else if (!adv) begin
        b_act = 0;
      end else if (b_act) begin
        b_n = (b_n + 1) % 4;
        nw.v = 1; nw.wr = b_wr; nw.a = baddr(b_base, b_n, lin);
      end
      nw.m = nw.wr ? ~bw_n : '0;
      p2 = p1;
      p1 = nw;
    end
    @(negedge clk);
    chk(drv == (ev && !oe_n), "drive_o", 64'(drv), 64'(ev && !oe_n));
    if (ev && !oe_n) chk(dout === ed, "data_o", 64'(dout), 64'(ed));
  endtask

  task automatic cmd(bit a_adv, bit a_wr, int a, logic [NB-1:0] m_n, logic [2:0] ce);
    adv = a_adv; wr_n = !a_wr; addr = AW'(a); bw_n = m_n; {ce1_n, ce2, ce3_n} = ce;
    tick();
  endtask

  task automatic rd(int a);                   cmd(0, 0, a, '1, 3'b010); endtask
  task automatic wr(int a, logic [NB-1:0] m); cmd(0, 1, a, m, 3'b010);  endtask
  task automatic desel();                     cmd(0, 0, 0, '1, 3'b110); endtask
  task automatic advc(bit w, logic [NB-1:0] m); cmd(1, w, 0, m, 3'b010); endtask
  task automatic stall(); cen_n = 1; tick(); cen_n = 0; endtask
  task automatic flush(); repeat (3) desel(); endtask

  initial begin
    p1.v = 0; p1.wr = 0; p1.a = 0; p1.m = '0;
    p2 = p1;
    repeat (3) @(negedge clk);
    req = "R12";
    chk(drv == 0, "drive_o in reset", 64'(drv), 64'd0);
    rst_n = 1;
    repeat (3) tick();

    // R1 R2: write every address with full masks, then read all back pipelined
    req = "R2"; seed = 1;
    for (int a = 0; a < DEPTH; a++) wr(a, '0);
    flush();
    req = "R1";
    for (int a = 0; a < DEPTH; a++) rd(a);
    flush();

    // R9: every byte mask on writes, reads carry random masks that must be ignored
    req = "R9"; seed = 2;
    for (int a = 0; a < DEPTH; a++) wr(a, NB'(a));
    flush();
    for (int a = 0; a < DEPTH; a++) cmd(0, 0, a, NB'(a * 5), 3'b010);
    flush();

    // R3: write, read same address next cycle and the cycle after, no gaps
    req = "R3"; seed = 3;
    for (int a = 0; a < 16; a++) begin wr(a, '0); rd(a); rd(a); wr(a + 16, NB'(a)); end
    flush();

    // R4: stalls inserted in the pipeline with inputs toggling
    req = "R4"; seed = 4;
    for (int a = 0; a < 8; a++) begin
      wr(a, '0); stall(); rd(a); stall(); stall(); rd(a ^ 1);
    end
    flush();

    // R5: every deselecting chip-enable combination, with a pending read ahead of it
    req = "R5"; seed = 5;
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) begin
        rd(40);
        cmd(0, 1, 40, '0, 3'(c));
        cmd(0, 1, 40, '0, 3'(c));
        flush();
        rd(40);
        flush();
      end
    end

    // R6: write then deselect; drive must fall exactly on time (checked each tick)
    req = "R6";
    rd(1); wr(2, '0); desel(); rd(3); desel(); desel(); rd(4); wr(4, '0); flush();

    // R8: both orders, all start offsets, write 4 beats then read 6 beats (wrap)
    for (int l = 0; l < 2; l++) begin
      for (int s = 0; s < 4; s++) begin
        req = "R8"; lin = l[0]; seed = 10 + l * 4 + s;
        wr(48 + s, '0);
        for (int n = 0; n < 3; n++) advc(0, NB'(n == 1 ? 3 : 0));  // wr_n ignored, masks used
        flush();
        req = "R8";
        rd(48 + s);
        for (int n = 0; n < 5; n++) advc(1, '0);
        flush();
      end
    end
    lin = 1;

    // R10: advance with no burst active must issue nothing
    req = "R10"; seed = 30;
    desel();
    for (int n = 0; n < 4; n++) advc(1, '0);
    flush();
    rd(48); advc(0, '0); flush();

    // R11: sleep holds pipeline and keeps contents
    req = "R11"; seed = 31;
    wr(5, '0); slp = 1; tick(); tick(); slp = 0; rd(5);
    slp = 1; repeat (3) tick(); slp = 0; flush();
    for (int a = 0; a < 8; a++) rd(a);
    flush();

    // R7: output enable acts without a clock edge
    req = "R7";
    rd(6); desel(); desel();
    #2 oe_n = 1; #1;
    chk(drv == 0, "drive_o with oe high", 64'(drv), 64'd0);
    chk(dout === ref_mem[6], "data_o kept", 64'(dout), 64'(ref_mem[6]));
    oe_n = 0; #1;
    chk(drv == 1, "drive_o after oe low", 64'(drv), 64'd1);
    flush();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog %s: actual hung expected done", req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule